// File: doc/BRIEF.md
# T1 Line Clock Digital PLL

This block derives a 1.544 MHz T1 line clock from a 12.352 MHz master clock and keeps the T1 frame aligned to an external 8 kHz frame reference. The reference is usually the system frame pulse fed back into the block. The line clock is the master clock divided by eight. A count of 193 line-clock periods makes one internal frame of 1544 master cycles. A one-cycle `frame_strobe` marks the first master cycle of each internal frame.

Each reference pulse is timed against the internal frame boundary. If the pulse falls within two master cycles of that boundary, either side, nothing is adjusted. This dead band absorbs slow wander, so the reference and the line clock have no fixed phase relationship. If the pulse falls outside the dead band, one divide period in that frame is lengthened to nine master cycles when the reference lags, or shortened to seven when it leads. Only one master cycle is moved per frame. Setting `hold_nominal` stops all adjustment, and the divider then runs at the nominal ratio.

A lock supervisor has three states:
- SEEK, the reset state. SEEK moves to HELD after four consecutive in-window pulses.
- HELD. HELD moves back to SEEK after four consecutive out-of-window pulses.
- NOREF. SEEK or HELD moves to NOREF when no reference pulse arrives for two nominal frames (3088 master cycles). Any pulse in NOREF moves the supervisor to SEEK. An in-window pulse that causes this exit counts as the first of a new run.

A synchronous reset is required after power-up.

Top module: `t1_line_dpll`

## Requirements
- R1: In the first master cycle after the synchronous reset is released, `frame_strobe` and `line_clk` are 1, and `locked` and `ref_lost` are 0.
- R2: Without adjustment, `line_clk` has a period of 8 master cycles: high for the first 4 cycles of each period, counted from the strobe cycle, and low for the next 4.
- R3: Without adjustment, `frame_strobe` is high for exactly one master cycle in every 1544 (193 line periods).
- R4: A reference pulse sampled d master cycles after the strobe cycle (d in 0..771 means the reference lags by d; d in 772..1543 means it leads by 1544-d) with an error of at most 2 leaves the next strobe interval at 1544 cycles.
- R5: A reference that lags by 3 or more cycles stretches one line period of that frame to 9 cycles, so the next strobe interval is 1545.
- R6: A reference that leads by 3 or more cycles shortens one line period of that frame to 7 cycles, so the next strobe interval is 1543.
- R7: While `hold_nominal` is 1, reference pulses cause no adjustment, and every strobe interval is 1544.
- R8: `locked` (supervisor state HELD) goes high after the fourth consecutive in-window pulse. An out-of-window pulse during SEEK restarts the count.
- R9: In HELD, `locked` falls after the fourth consecutive out-of-window pulse. An in-window pulse restarts that count.
- R10: After 3088 master cycles without a reference pulse, `ref_lost` (state NOREF) is 1 and `locked` is 0, while the strobe interval stays 1544.
- R11: A reference pulse in NOREF returns the supervisor to SEEK, so `ref_lost` is 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_master | input | 1 | 12.352 MHz master clock |
| rst | input | 1 | Synchronous reset, active high |
| hold_nominal | input | 1 | 1 = no phase adjustment (free run), 0 = tracking |
| frame_ref | input | 1 | 8 kHz reference frame pulse, one master cycle wide, synchronous |
| line_clk | output | 1 | 1.544 MHz line clock |
| frame_strobe | output | 1 | One-cycle marker of the internal frame start |
| locked | output | 1 | Supervisor is in HELD |
| ref_lost | output | 1 | Supervisor is in NOREF |

## Verification
A reference pulse is registered at the master edge that ends its cycle. Any pending adjustment then takes effect within the current divide period, so the frame that contains the pulse shows the result. The bench therefore measures the interval from the strobe before each pulse to the strobe after it. The bench sweeps the phase error from -6 to +6, which covers both edges of the dead band. Supervisor changes appear one cycle after the deciding pulse, and the bench reads them at the following strobe. The loss-of-reference check samples well before and well after the 3088-cycle limit. All sampling is done at the falling edge.

// File: rtl/t1pll_pkg.sv
package t1pll_pkg;
    typedef enum logic [1:0] {
        ST_SEEK  = 2'd0,
        ST_HELD  = 2'd1,
        ST_NOREF = 2'd2
    } lock_state_t;

    typedef enum logic [1:0] {
        ADJ_NONE    = 2'd0,
        ADJ_STRETCH = 2'd1,
        ADJ_SHRINK  = 2'd2
    } adj_t;
endpackage

// File: rtl/t1_bit_divider.sv
module t1_bit_divider
    import t1pll_pkg::*;
#(
    parameter int DIV  = 8,
    parameter int BITS = 193,
    parameter int POSW = 11
) (
    input  logic            clk,
    input  logic            rst,
    input  adj_t            adj_req,
    output logic            line_clk,
    output logic            frame_strobe,
    output logic [POSW-1:0] frame_pos
);
    localparam int PW = $clog2(DIV + 1);
    localparam int BW = $clog2(BITS);

    logic [PW-1:0] ph;
    logic [BW-1:0] bc;
    adj_t          pend;
    logic          wrap_normal, wrap_stretch, wrap_shrink, wrap;

    always_comb begin
        wrap_stretch = (pend == ADJ_STRETCH) && (ph == PW'(DIV));
        wrap_shrink  = (pend == ADJ_SHRINK)  && (ph == PW'(DIV - 2));
        wrap_normal  = (pend != ADJ_STRETCH) && (ph == PW'(DIV - 1));
        wrap         = wrap_stretch || wrap_shrink || wrap_normal;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= '0;
            bc   <= '0;
            pend <= ADJ_NONE;
        end else begin
            if (wrap) begin
                ph <= '0;
                bc <= (bc == BW'(BITS - 1)) ? '0 : bc + 1'b1;
            end else begin
                ph <= ph + 1'b1;
            end
            if (adj_req != ADJ_NONE)
                pend <= adj_req;
            else if (wrap_stretch || wrap_shrink)
                pend <= ADJ_NONE;
        end
    end

    always_comb begin
        line_clk     = (ph < PW'(DIV / 2));
        frame_strobe = (bc == '0) && (ph == '0);
        frame_pos    = POSW'(bc) * POSW'(DIV) + POSW'(ph);
    end

    assert_phase_bound_R5: assert property (@(posedge clk) disable iff (rst)
        ph <= PW'(DIV));
    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (rst)
        frame_strobe |=> !frame_strobe);
    assert_stretch_only_on_request_R5: assert property (@(posedge clk) disable iff (rst)
        (ph == PW'(DIV)) |-> (pend == ADJ_STRETCH));
endmodule

// File: rtl/t1_phase_cmp.sv
module t1_phase_cmp
    import t1pll_pkg::*;
#(
    parameter int FRAME_LEN = 1544,
    parameter int WIN       = 2,
    parameter int POSW      = 11
) (
    input  logic [POSW-1:0] frame_pos,
    input  logic            ref_pulse,
    input  logic            hold,
    output logic            in_win,
    output adj_t            adj_req
);
    always_comb begin
        in_win  = (frame_pos <= POSW'(WIN)) || (frame_pos >= POSW'(FRAME_LEN - WIN));
        adj_req = ADJ_NONE;
        if (ref_pulse && !hold && !in_win)
            adj_req = (frame_pos < POSW'(FRAME_LEN / 2)) ? ADJ_STRETCH : ADJ_SHRINK;
    end
endmodule

// File: rtl/t1_lock_fsm.sv
module t1_lock_fsm
    import t1pll_pkg::*;
#(
    parameter int RUN_LEN  = 4,
    parameter int LOSS_CYC = 3088
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_pulse,
    input  logic in_win,
    output logic locked,
    output logic ref_lost
);
    localparam int RW = $clog2(RUN_LEN + 1);
    localparam int SW = $clog2(LOSS_CYC + 1);

    lock_state_t   state, state_nx;
    logic [RW-1:0] run;
    logic [SW-1:0] silence;
    logic          timeout;

    assign timeout = (silence == SW'(LOSS_CYC)) && !ref_pulse;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_SEEK:  if (timeout) state_nx = ST_NOREF;
                      else if (ref_pulse && in_win && run == RW'(RUN_LEN - 1)) state_nx = ST_HELD;
            ST_HELD:  if (timeout) state_nx = ST_NOREF;
                      else if (ref_pulse && !in_win && run == RW'(RUN_LEN - 1)) state_nx = ST_SEEK;
            ST_NOREF: if (ref_pulse) state_nx = ST_SEEK;
            default:  state_nx = ST_SEEK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_SEEK;
            run     <= '0;
            silence <= '0;
        end else begin
            state <= state_nx;
            if (ref_pulse)
                silence <= '0;
            else if (silence != SW'(LOSS_CYC))
                silence <= silence + 1'b1;
            if (state_nx != state)
                run <= (state == ST_NOREF && in_win) ? RW'(1) : '0;
            else if (ref_pulse && state == ST_SEEK)
                run <= in_win ? run + 1'b1 : '0;
            else if (ref_pulse && state == ST_HELD)
                run <= in_win ? '0 : run + 1'b1;
        end
    end

    always_comb begin
        locked   = (state == ST_HELD);
        ref_lost = (state == ST_NOREF);
    end

    assert_lock_after_good_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(ref_pulse && in_win));
    assert_unlock_cause_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> $past(timeout || (ref_pulse && !in_win)));
    assert_loss_needs_silence_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(ref_lost) |-> !$past(ref_pulse));
    assert_pulse_clears_loss_R11: assert property (@(posedge clk) disable iff (rst)
        (ref_lost && ref_pulse) |=> !ref_lost);
endmodule

// File: rtl/t1_line_dpll.sv
module t1_line_dpll
    import t1pll_pkg::*;
#(
    parameter int DIV            = 8,
    parameter int BITS_PER_FRAME = 193,
    parameter int WINDOW         = 2,
    parameter int RUN_LEN        = 4,
    parameter int LOSS_FRAMES    = 2
) (
    input  logic clk_master,
    input  logic rst,
    input  logic hold_nominal,
    input  logic frame_ref,
    output logic line_clk,
    output logic frame_strobe,
    output logic locked,
    output logic ref_lost
);
    localparam int FRAME_LEN = DIV * BITS_PER_FRAME;
    localparam int POSW      = $clog2(FRAME_LEN + DIV);
    localparam int LOSS_CYC  = LOSS_FRAMES * FRAME_LEN;

    logic [POSW-1:0] frame_pos;
    logic            in_win;
    adj_t            adj_req;

    t1_bit_divider #(.DIV(DIV), .BITS(BITS_PER_FRAME), .POSW(POSW)) u_div (
        .clk          (clk_master),
        .rst          (rst),
        .adj_req      (adj_req),
        .line_clk     (line_clk),
        .frame_strobe (frame_strobe),
        .frame_pos    (frame_pos)
    );

    t1_phase_cmp #(.FRAME_LEN(FRAME_LEN), .WIN(WINDOW), .POSW(POSW)) u_cmp (
        .frame_pos (frame_pos),
        .ref_pulse (frame_ref),
        .hold      (hold_nominal),
        .in_win    (in_win),
        .adj_req   (adj_req)
    );

    t1_lock_fsm #(.RUN_LEN(RUN_LEN), .LOSS_CYC(LOSS_CYC)) u_lock (
        .clk       (clk_master),
        .rst       (rst),
        .ref_pulse (frame_ref),
        .in_win    (in_win),
        .locked    (locked),
        .ref_lost  (ref_lost)
    );
endmodule

// File: tb/test_t1_line_dpll.sv
module test_t1_line_dpll;
    localparam int CLK_PERIOD = 10;
    localparam int NOM = 1544;

    logic clk = 1'b0;
    logic rst, hold_nominal, frame_ref;
    logic line_clk, frame_strobe, locked, ref_lost;
    int   cyc = 0;
    int   total = 0;
    int   bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    t1_line_dpll i_t1_line_dpll (
        .clk_master   (clk),
        .rst          (rst),
        .hold_nominal (hold_nominal),
        .frame_ref    (frame_ref),
        .line_clk     (line_clk),
        .frame_strobe (frame_strobe),
        .locked       (locked),
        .ref_lost     (ref_lost)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        frame_ref = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_strobe();
        do @(negedge clk); while (!frame_strobe);
    endtask

    // Starts on a strobe negedge, pulses at offset off, ends on next strobe.
    task automatic pulse_frame(input int off, output int iv);
        int t;
        t = cyc;
        repeat (off) @(negedge clk);
        frame_ref = 1'b1;
        @(negedge clk);
        frame_ref = 1'b0;
        while (!frame_strobe) @(negedge clk);
        iv = cyc - t;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int t0, iv, e, exp;
        string tag;
        hold_nominal = 1'b0;
        do_reset();
        t0 = cyc;
        chk("R1 strobe", frame_strobe, 1);
        chk("R1 line_clk", line_clk, 1);
        chk("R1 locked", locked, 0);
        chk("R1 ref_lost", ref_lost, 0);
        for (int n = 1; n <= 16; n++) begin
            @(negedge clk);
            chk("R2 line_clk", line_clk, ((n % 8) < 4) ? 1 : 0);
        end
        wait_strobe();
        chk("R3 interval", cyc - t0, NOM);

        // phase error sweep -6..+6 (R4 inside window, R5 lag, R6 lead)
        for (int i = 0; i < 13; i++) begin
            e = (i <= 6) ? i : i - 13;
            pulse_frame((e >= 0) ? e : NOM + e, iv);
            exp = NOM + ((e > 2) ? 1 : 0) - ((e < -2) ? 1 : 0);
            tag = (e > 2) ? "R5 lag" : ((e < -2) ? "R6 lead" : "R4 window");
            chk(tag, iv, exp);
        end

        // R8: interrupted run, then a full run
        do_reset();
        for (int k = 0; k < 7; k++) begin
            pulse_frame((k == 3) ? 10 : 0, iv);
        end
        chk("R8 interrupted run", locked, 0);
        pulse_frame(0, iv);
        chk("R8 four good", locked, 1);

        // R9: interrupted miss run keeps lock, full miss run drops it
        for (int k = 0; k < 7; k++) begin
            pulse_frame((k == 3) ? 0 : 10, iv);
        end
        chk("R9 interrupted misses", locked, 1);
        pulse_frame(10, iv);
        chk("R9 four misses", locked, 0);

        // R7: hold mode ignores phase error
        hold_nominal = 1'b1;
        pulse_frame(10, iv);
        chk("R7 hold lag", iv, NOM);
        pulse_frame(NOM - 10, iv);
        chk("R7 hold lead", iv, NOM);
        hold_nominal = 1'b0;

        // R10/R11: loss of reference
        pulse_frame(0, iv);
        repeat (1500) @(negedge clk);
        chk("R10 before limit", ref_lost, 0);
        repeat (100) @(negedge clk);
        chk("R10 ref_lost", ref_lost, 1);
        chk("R10 locked", locked, 0);
        wait_strobe();
        t0 = cyc;
        wait_strobe();
        chk("R10 nominal interval", cyc - t0, NOM);
        pulse_frame(0, iv);
        chk("R11 ref_lost cleared", ref_lost, 0);
        chk("R11 seeking", locked, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule